// File: doc/BRIEF.md
# Framed Infrared Receive Buffer

This block sits behind the symbol decoder of a framed infrared serial receiver. Each decoded byte is offered on a one-cycle strobe, optionally marked as the closing byte of its frame. The decoder also reports an illegal physical symbol and a failed frame checksum on separate strobes. Accepted bytes go into a FIFO whose entries carry a frame-end tag, so several complete frames can be queued and still be told apart when read.

While a frame is arriving, the block counts its bytes against a 16-bit maximum length that software supplies as a low byte and a high byte. Bytes beyond that limit, bytes that arrive while the FIFO is full, and the rest of a frame cut short by an illegal symbol are not stored. When the closing byte of a frame is lost, the frame-end tag moves to the newest byte of that frame that was stored.

An 8-bit status word reports on the head of the FIFO and keeps four sticky error flags. A status-read strobe clears those flags.

Top module: `irrx_frame_fifo`

## Requirements
- R1: After a synchronous reset the status word reads 0x00 and the FIFO is empty.
- R2: Status bit 0 is 1 exactly when the FIFO holds at least one entry. `head_byte` shows the oldest stored byte. A `pop_req` removes it, and bytes leave in the order they arrived.
- R3: A byte offered with `rx_last` is stored with its frame-end tag set. Status bit 7 is 1 exactly when the FIFO is not empty and its head entry carries the tag.
- R4: The maximum length is {`max_len_hi`,`max_len_lo`}. A byte whose 1-based position in the current frame exceeds that value sets status bit 5 and is not stored. No later byte of that frame is stored either.
- R5: An `rx_sym_err` strobe sets status bit 4 and ends the current frame. A byte offered in the same cycle is discarded.
- R6: An `rx_crc_err` strobe sets status bit 2.
- R7: A byte that arrives within the length limit while the FIFO holds DEPTH entries sets status bit 1 and is dropped. The stored entries are unchanged, even if a pop occurs in the same cycle.
- R8: Status bits 5, 4, 2 and 1 are sticky until a `stat_rd` strobe clears them. If an event that sets a flag falls in the same cycle as the read, that flag stays set.
- R9: The per-frame byte count returns to zero at every frame end, including one forced by `rx_sym_err`. The next frame therefore gets the full length allowance.
- R10: A `pop_req` on an empty FIFO has no effect. A push and a pop in the same cycle on a FIFO that is neither empty nor full leave the occupancy unchanged.
- R11: When a frame ends without its own closing byte being stored (the byte was dropped by R4 or R7, or the frame was aborted by R5), the newest stored entry gets the frame-end tag. This happens only if at least one byte of that frame was stored and that entry is still in the FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | 1 | A decoded byte is offered this cycle |
| rx_byte | input | 8 | Decoded byte |
| rx_last | input | 1 | The offered byte closes its frame |
| rx_sym_err | input | 1 | Illegal physical symbol strobe; aborts the frame |
| rx_crc_err | input | 1 | Frame checksum failure strobe |
| max_len_lo | input | 8 | Maximum frame length, low byte |
| max_len_hi | input | 8 | Maximum frame length, high byte |
| pop_req | input | 1 | Remove the head entry |
| head_byte | output | 8 | Data byte at the FIFO head |
| stat_rd | input | 1 | Status read strobe; clears the sticky flags |
| rx_status | output | 8 | {last-byte, 0, max-len, phy-err, 0, crc-err, overrun, data-ready} |

## Verification
The collision that matters most is the end of a frame landing in the same cycle as another event. The bench provokes several of them. A dropped closing byte or an abort arrives while a pop is removing the entry that would be re-tagged. A byte arrives at a full FIFO in the same cycle as a pop. A checksum or symbol error strobe coincides with a status read. A behavioural queue model derives the expected head byte, tag and flags for every cycle from the requirements, and each field is compared after every clock edge.

// File: rtl/irrx_pkg.sv
// Shared types and status bit positions for the framed infrared receive buffer.
package irrx_pkg;

    // One FIFO entry: a data byte plus the frame-end tag.
    typedef struct packed {
        logic       eof;
        logic [7:0] data;
    } rx_entry_t;

    // Status bit positions. Software decodes these, so they are fixed.
    localparam int unsigned STAT_LB  = 7;
    localparam int unsigned STAT_MLX = 5;
    localparam int unsigned STAT_PHY = 4;
    localparam int unsigned STAT_CRC = 2;
    localparam int unsigned STAT_OVR = 1;
    localparam int unsigned STAT_RDR = 0;

    // Order of the sticky flags inside the flag vector.
    localparam int unsigned FLG_OVR = 0;
    localparam int unsigned FLG_CRC = 1;
    localparam int unsigned FLG_PHY = 2;
    localparam int unsigned FLG_MLX = 3;
    localparam int unsigned NUM_FLAGS = 4;

endpackage

// File: rtl/irrx_fifo_mem.sv
// Tagged circular FIFO.
// What it does: stores rx_entry_t words and shows the oldest one at its head.
//   It can also set the frame-end tag of the newest stored entry.
// Assumes: DEPTH >= 2; the caller never pushes when full; tag_newest and
//   push are never active in the same cycle.
module irrx_fifo_mem
    import irrx_pkg::*;
#(
    parameter int unsigned DEPTH = 32,
    localparam int unsigned AW = $clog2(DEPTH),
    localparam int unsigned CW = $clog2(DEPTH + 1)
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      push,
    input  rx_entry_t push_entry,
    input  logic      pop,
    input  logic      tag_newest,
    output rx_entry_t head,
    output logic      empty,
    output logic      full,
    output logic [CW-1:0] fill
);

    localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    rx_entry_t       mem [DEPTH];
    logic [AW-1:0]   wr_ptr, rd_ptr, newest_idx;
    logic [CW-1:0]   count;
    logic            do_pop;

    function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
        return (p == LAST_IDX) ? '0 : p + 1'b1;
    endfunction

    assign empty      = (count == '0);
    assign full       = (count == FULL_CNT);
    assign fill       = count;
    assign do_pop     = pop && !empty;
    assign newest_idx = (wr_ptr == '0) ? LAST_IDX : wr_ptr - 1'b1;
    assign head       = mem[rd_ptr];

    // Storage: write a new entry, or mark the newest one as a frame end.
    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_ptr] <= push_entry;
        end else if (tag_newest) begin
            mem[newest_idx].eof <= 1'b1;
        end
    end

    // Pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push)   wr_ptr <= ptr_inc(wr_ptr);
            if (do_pop) rd_ptr <= ptr_inc(rd_ptr);
            case ({push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/irrx_len_ctrl.sv
// Frame admission control.
// What it does: counts the bytes of the current frame and checks them against
//   the programmed maximum. It decides whether each offered byte is stored,
//   flags length and overrun events, and requests re-tagging when a frame ends
//   without its closing byte stored.
// Assumes: the FIFO status inputs describe the state before this edge.
module irrx_len_ctrl #(
    parameter int unsigned LEN_W = 16,
    localparam int unsigned CNT_W = LEN_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_valid,
    input  logic             rx_last,
    input  logic             rx_sym_err,
    input  logic [LEN_W-1:0] max_len,
    input  logic             fifo_full,
    input  logic             fifo_empty,
    output logic             push,
    output logic             ovr_ev,
    output logic             mlx_ev,
    output logic             tag_newest
);

    logic [CNT_W-1:0] rx_cnt, cnt_inc;
    logic             blocked;    // length exceeded earlier in this frame
    logic             stored_any; // at least one byte of this frame stored
    logic             byte_ev, over, close, admit;

    assign byte_ev    = rx_valid && !rx_sym_err;              // R5: abort wins
    assign cnt_inc    = (&rx_cnt) ? rx_cnt : rx_cnt + 1'b1;
    assign over       = cnt_inc > {1'b0, max_len};            // R4
    assign admit      = byte_ev && !blocked && !over;
    assign push       = admit && !fifo_full;
    assign ovr_ev     = admit && fifo_full;                   // R7
    assign mlx_ev     = byte_ev && over;
    assign close      = rx_sym_err || (byte_ev && rx_last);
    assign tag_newest = close && !push && stored_any && !fifo_empty; // R11

    // Per-frame counter and frame state; cleared at every frame end (R9).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_cnt     <= '0;
            blocked    <= 1'b0;
            stored_any <= 1'b0;
        end else if (close) begin
            rx_cnt     <= '0;
            blocked    <= 1'b0;
            stored_any <= 1'b0;
        end else if (byte_ev) begin
            rx_cnt     <= cnt_inc;
            blocked    <= blocked || over;
            stored_any <= stored_any || push;
        end
    end

endmodule

// File: rtl/irrx_stat_flags.sv
// Sticky error flags.
// What it does: holds one flag per error event. Each flag is set by its event
//   and cleared by a status read; an event in the read cycle wins.
// Assumes: event inputs are single-cycle strobes.
module irrx_stat_flags #(
    parameter int unsigned NFLAGS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stat_rd,
    input  logic [NFLAGS-1:0] ev,
    output logic [NFLAGS-1:0] flags
);

    for (genvar i = 0; i < NFLAGS; i++) begin : g_flag
        // Flag i: set on its event, cleared by a read without a new event (R8).
        always_ff @(posedge clk) begin
            if (!rst_n) flags[i] <= 1'b0;
            else        flags[i] <= (flags[i] && !stat_rd) || ev[i];
        end
    end

endmodule

// File: rtl/irrx_frame_fifo.sv
// Framed infrared receive buffer, top level.
// What it does: admits decoded bytes into a frame-tagged FIFO under length and
//   space checks, and assembles the status word from the head entry and the
//   sticky flags.
// Assumes: all inputs are synchronous to clk; strobes last one cycle.
module irrx_frame_fifo
    import irrx_pkg::*;
#(
    parameter int unsigned DEPTH = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_valid,
    input  logic [7:0] rx_byte,
    input  logic       rx_last,
    input  logic       rx_sym_err,
    input  logic       rx_crc_err,
    input  logic [7:0] max_len_lo,
    input  logic [7:0] max_len_hi,
    input  logic       pop_req,
    output logic [7:0] head_byte,
    input  logic       stat_rd,
    output logic [7:0] rx_status
);

    localparam int unsigned LEN_W = 16;
    localparam int unsigned CW    = $clog2(DEPTH + 1);

    logic                 push, ovr_ev, mlx_ev, tag_newest;
    logic                 fifo_empty, fifo_full;
    logic [CW-1:0]        fill_cnt;
    rx_entry_t            head, push_entry;
    logic [NUM_FLAGS-1:0] ev, flags;

    assign push_entry = '{eof: rx_last, data: rx_byte};

    irrx_len_ctrl #(.LEN_W(LEN_W)) u_len (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_valid   (rx_valid),
        .rx_last    (rx_last),
        .rx_sym_err (rx_sym_err),
        .max_len    ({max_len_hi, max_len_lo}),
        .fifo_full  (fifo_full),
        .fifo_empty (fifo_empty),
        .push       (push),
        .ovr_ev     (ovr_ev),
        .mlx_ev     (mlx_ev),
        .tag_newest (tag_newest)
    );

    irrx_fifo_mem #(.DEPTH(DEPTH)) u_fifo (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (push),
        .push_entry (push_entry),
        .pop        (pop_req),
        .tag_newest (tag_newest),
        .head       (head),
        .empty      (fifo_empty),
        .full       (fifo_full),
        .fill       (fill_cnt)
    );

    // Map the events onto the flag vector.
    always_comb begin
        ev          = '0;
        ev[FLG_OVR] = ovr_ev;
        ev[FLG_CRC] = rx_crc_err;
        ev[FLG_PHY] = rx_sym_err;
        ev[FLG_MLX] = mlx_ev;
    end

    irrx_stat_flags #(.NFLAGS(NUM_FLAGS)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .stat_rd (stat_rd),
        .ev      (ev),
        .flags   (flags)
    );

    assign head_byte = head.data;

    // Assemble the status word.
    always_comb begin
        rx_status           = '0;
        rx_status[STAT_LB]  = !fifo_empty && head.eof;
        rx_status[STAT_MLX] = flags[FLG_MLX];
        rx_status[STAT_PHY] = flags[FLG_PHY];
        rx_status[STAT_CRC] = flags[FLG_CRC];
        rx_status[STAT_OVR] = flags[FLG_OVR];
        rx_status[STAT_RDR] = !fifo_empty;
    end

endmodule

// File: rtl/irrx_frame_fifo_chk.sv
// Assertion checker for irrx_frame_fifo. It is attached by the bind below.
module irrx_frame_fifo_chk #(
    parameter int unsigned DEPTH = 32,
    localparam int unsigned CW = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rx_valid,
    input logic          rx_sym_err,
    input logic          rx_crc_err,
    input logic          pop_req,
    input logic          stat_rd,
    input logic [7:0]    rx_status,
    input logic [CW-1:0] fill
);

    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (rx_status == 8'h00 && fill == '0));

    p_ready_tracks_fill_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rx_status[0] == (fill != '0));

    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= FULL_CNT);

    p_full_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fill == FULL_CNT && !pop_req) |=> fill == FULL_CNT);

    p_phy_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_sym_err |=> rx_status[4]);

    p_crc_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_crc_err |=> rx_status[2]);

    p_ovr_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_status[1] && !stat_rd) |=> rx_status[1]);

    p_empty_pop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (fill == '0 && pop_req && !rx_valid) |=> fill == '0);

endmodule

bind irrx_frame_fifo irrx_frame_fifo_chk #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_valid   (rx_valid),
    .rx_sym_err (rx_sym_err),
    .rx_crc_err (rx_crc_err),
    .pop_req    (pop_req),
    .stat_rd    (stat_rd),
    .rx_status  (rx_status),
    .fill       (fill_cnt)
);

// File: tb/irrx_frame_fifo_test.sv
module irrx_frame_fifo_test;

    localparam int DEPTH = 32;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_valid = 0, rx_last = 0, rx_sym_err = 0, rx_crc_err = 0;
    logic [7:0] rx_byte = 0, max_len_lo = 0, max_len_hi = 0;
    logic       pop_req = 0, stat_rd = 0;
    logic [7:0] head_byte, rx_status;

    int checks = 0;
    int fails  = 0;

    // Reference model state.
    logic [8:0] q[$];
    int         m_cnt;
    bit         m_blk, m_wr;
    bit         f_mlx, f_phy, f_crc, f_ovr;

    always #5 clk = ~clk;

    irrx_frame_fifo #(.DEPTH(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .rx_last(rx_last), .rx_sym_err(rx_sym_err), .rx_crc_err(rx_crc_err),
        .max_len_lo(max_len_lo), .max_len_hi(max_len_hi), .pop_req(pop_req),
        .head_byte(head_byte), .stat_rd(stat_rd), .rx_status(rx_status)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // Advance the model by one clock edge, using the inputs held for that edge.
    task automatic model_step();
        int  sz = q.size();
        bit  full = (sz == DEPTH), empty = (sz == 0);
        bit  pop = pop_req && !empty;
        bit  bev = rx_valid && !rx_sym_err;
        int  maxv = {max_len_hi, max_len_lo};
        bit  over = (m_cnt + 1) > maxv;
        bit  admit = bev && !m_blk && !over;
        bit  push = admit && !full;
        bit  ovr = admit && full;
        bit  close = rx_sym_err || (bev && rx_last);
        bit  tagn = close && !push && m_wr && !empty;
        if (!rst_n) begin
            q.delete(); m_cnt = 0; m_blk = 0; m_wr = 0;
            f_mlx = 0; f_phy = 0; f_crc = 0; f_ovr = 0;
            return;
        end
        f_mlx = (f_mlx && !stat_rd) || (bev && over);
        f_phy = (f_phy && !stat_rd) || rx_sym_err;
        f_crc = (f_crc && !stat_rd) || rx_crc_err;
        f_ovr = (f_ovr && !stat_rd) || ovr;
        if (tagn) q[sz-1][8] = 1'b1;
        if (pop) void'(q.pop_front());
        if (push) q.push_back({rx_last, rx_byte});
        if (close) begin m_cnt = 0; m_blk = 0; m_wr = 0; end
        else if (bev) begin
            m_cnt++;
            if (over) m_blk = 1;
            if (push) m_wr = 1;
        end
    endtask

    // Compare every status field and the head byte against the model.
    task automatic compare();
        bit ne = (q.size() != 0);
        chk("R3 last-byte bit", rx_status[7], ne ? int'(q[0][8]) : 0);
        chk("R4 max-len bit",   rx_status[5], f_mlx);
        chk("R5 phy-err bit",   rx_status[4], f_phy);
        chk("R6 crc-err bit",   rx_status[2], f_crc);
        chk("R7 overrun bit",   rx_status[1], f_ovr);
        chk("R2 data-ready bit", rx_status[0], ne);
        chk("R1 unused bits",   {rx_status[6], rx_status[3]}, 0);
        if (ne) chk("R2 head byte", head_byte, q[0][7:0]);
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        if (rst_n) compare();
    endtask

    task automatic cyc(input bit v, input logic [7:0] b, input bit last,
                       input bit sym, input bit crc, input bit pop, input bit srd);
        rx_valid = v; rx_byte = b; rx_last = last; rx_sym_err = sym;
        rx_crc_err = crc; pop_req = pop; stat_rd = srd;
        tick();
    endtask

    task automatic idle(); cyc(0, 8'h00, 0, 0, 0, 0, 0); endtask
    task automatic put(input logic [7:0] b, input bit last); cyc(1, b, last, 0, 0, 0, 0); endtask
    task automatic pop1(); cyc(0, 8'h00, 0, 0, 0, 1, 0); endtask
    task automatic sread(); cyc(0, 8'h00, 0, 0, 0, 0, 1); endtask
    task automatic set_max(input int m); max_len_lo = m[7:0]; max_len_hi = m[15:8]; endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        set_max(16'h0010);
        repeat (3) tick();
        rst_n = 1'b1;
        idle();
        chk("R1 status after reset", rx_status, 8'h00);

        // R2/R3: two whole frames are queued and read back in order.
        put(8'hA1, 0); put(8'hA2, 0); put(8'hA3, 1);
        put(8'hB1, 0); put(8'hB2, 1);
        chk("R2 first head", head_byte, 8'hA1);
        pop1(); pop1();
        chk("R3 frame end at head", rx_status[7], 1);
        pop1();
        chk("R2 second frame head", head_byte, 8'hB1);
        // R10: a push and a pop in the same cycle
        cyc(1, 8'hC1, 1, 0, 0, 1, 0);
        pop1(); pop1(); pop1();
        cyc(0, 8'h00, 0, 0, 0, 1, 0);  // R10: pop on an empty FIFO
        chk("R10 empty stays empty", rx_status[0], 0);

        // R4/R11: a 5-byte frame against a maximum of 3
        set_max(3);
        for (int i = 1; i <= 5; i++) put(8'h10 + 8'(i), i == 5);
        chk("R4 max-len flag", rx_status[5], 1);
        pop1(); pop1();
        chk("R11 tag moved to third byte", rx_status[7], 1);
        chk("R4 third byte kept", head_byte, 8'h13);
        pop1();
        sread();
        chk("R8 flags cleared by read", rx_status & 8'h36, 0);

        // R5/R9: an aborted frame, then a full-length frame is accepted
        put(8'h21, 0); put(8'h22, 0);
        cyc(1, 8'hEE, 0, 1, 0, 0, 0);   // abort, and the byte is discarded
        chk("R5 phy flag", rx_status[4], 1);
        put(8'h31, 0); put(8'h32, 0); put(8'h33, 1);
        pop1();
        chk("R11 abort tag", rx_status[7], 1);
        pop1();
        chk("R9 new frame accepted", head_byte, 8'h31);
        pop1(); pop1(); pop1();
        // abort while the re-tagged entry is being popped
        put(8'h41, 0);
        cyc(0, 8'h00, 0, 1, 0, 1, 0);

        // R6/R8: error events in the same cycle as a status read
        cyc(1, 8'h51, 1, 0, 1, 0, 1);
        chk("R8 crc survives same-cycle read", rx_status[2], 1);
        cyc(0, 8'h00, 0, 1, 0, 1, 1);
        chk("R8 phy survives same-cycle read", rx_status[4], 1);
        sread();

        // R7: fill the FIFO, overflow it, and lose the closing byte
        set_max(16'hFFFF);
        for (int i = 0; i < DEPTH; i++) put(8'(i), 0);
        put(8'hF0, 0);
        chk("R7 overrun flag", rx_status[1], 1);
        cyc(1, 8'hF1, 1, 0, 0, 1, 0);  // full: dropped despite the pop
        chk("R7 kept head after drop", head_byte, 8'h01);
        for (int i = 0; i < DEPTH - 2; i++) pop1();
        chk("R11 tag on newest after overrun", rx_status[7], 1);
        pop1(); pop1();
        sread();

        // R4: the high byte of the limit (256), streaming with pops
        set_max(16'h0100);
        for (int i = 0; i < 258; i++) cyc(1, 8'(i), i == 257, 0, 0, 1, 0);
        chk("R4 high-byte limit", rx_status[5], 1);
        pop1(); pop1();
        idle();
        chk("R2 drained", rx_status[0], 0);

        finish_run();
    end

endmodule